// File: doc/BRIEF.md
# Three-Channel Compare Timer

The block is one timer channel built around a 16-bit up-counter that advances on each cycle of a count strobe while a run bit is set. Three compare registers (A, B, C) are checked against the counter on every advancing cycle. Each register owns one output pin, and a per-pin action code sets what a match does to that pin. Each register also owns a sticky match flag.

Register A can act as the period register. In that mode the counter returns to zero after it matches A, so the period is A+1 strobes. A keep-running bit selects whether a match on A stops the count. Each pin has a programmed initial level that is driven before counting starts. That level is loaded into the pin flop on the start that follows a reset or an explicit re-prime request. A stop followed by a restart continues from the held count and the held pin levels.

Software configures the block through a write-only register port. The pins are brought out as a level and an active-high drive enable, so a tri-state pad can be attached outside.

Top module: `cmp_timer`

## Requirements
- R1: After reset the count is 0, all flags are 0, the block is primed with initial levels 0 so every pin level is 0, every pin is driven, and the run bit is 0.
- R2: While the run bit (address 0, bit 0) is 1, the count rises by one on each clock where tick_en is 1. It does not change on clocks where tick_en is 0.
- R3: When the clear code (address 1, bits 2:0) is 001, an advancing cycle that sees count equal to compare A (address 5) loads 0, which gives a period of A+1 strobes. Any other code lets the count run on past A and wrap from 0xFFFF to 0.
- R4: Action fields sit at address 2: bits 1:0 for A, bits 5:4 for B and bits 9:8 for C. Bits 3:2, 7:6 and 11:10 are ignored. Codes are 00 none, 01 drive low, 10 drive high and 11 toggle, and the action is applied on the same edge as the match on that channel's compare register (addresses 5, 6, 7).
- R5: The initial levels are at address 3, bits 2:0 (bit 0 is A). While primed, each pin shows its initial level. A write of run=1 while run is 0 and primed loads those levels into the pin flops and ends priming. Writing address 0 with bit 2 set re-primes the block. A restart without priming keeps the held levels.
- R6: A match sets that channel's flag (flag_o bit 0 is A), and the flag stays set. Writing address 4 with bit k equal to 0 clears flag k. A 1 in bit k leaves flag k unchanged.
- R7: If a flag clear and a new match on the same channel happen on the same clock, the flag ends up set.
- R8: With the keep-running bit (address 0, bit 1) at 0, a match on A clears the run bit after that edge's count update. With it at 1, counting continues.
- R9: While run is 0, the count and all pin levels hold. Setting run again resumes from the held count.
- R10: Address 3, bits 6:4 are active-low output enables (bit 4 is A). A 1 in one of these bits drives the matching pin_drv_o bit to 0, and a 0 drives it to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| count_o | output | 16 | Current counter value |
| flag_o | output | 3 | Sticky match flags, bit 0 = A |
| pin_lvl_o | output | 3 | Pin levels, bit 0 = A |
| pin_drv_o | output | 3 | Pin drive enables, 1 = driven |

## Verification
A wrong counter update shows up on count_o at the next advancing edge. A bad clear or wrap also shifts every later match by whole periods, so the pin pattern drifts from the expected sequence within one period. A wrongly decoded action, or a toggle flop that loses its state, changes pin_lvl_o on the edge of the match itself. A priming bit that is left wrong shows up on the first start or the first resume, as a pin that jumps to its initial level or fails to reach it. Flag logic errors appear on flag_o on the edge after the match or after the clearing write, including the cycle where the two collide.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int NUM_CH = 3;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  localparam logic [ADDR_W-1:0] AD_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] AD_CLR  = 3'd1;
  localparam logic [ADDR_W-1:0] AD_ACT  = 3'd2;
  localparam logic [ADDR_W-1:0] AD_PIN  = 3'd3;
  localparam logic [ADDR_W-1:0] AD_FLAG = 3'd4;
  localparam logic [ADDR_W-1:0] AD_CMP0 = 3'd5;

  localparam logic [2:0] CLR_ON_A = 3'b001;
endpackage

// File: rtl/cmt_regs.sv
module cmt_regs
  import cmt_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int NC = NUM_CH
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      hit_a_i,
  output logic                      run_o,
  output logic                      clr_on_a_o,
  output logic [NC-1:0][1:0]        act_o,
  output logic [NC-1:0]             init_o,
  output logic [NC-1:0]             drv_o,
  output logic [NC-1:0][CW-1:0]     cmp_o,
  output logic [NC-1:0]             flag_clr_o,
  output logic                      load_o,
  output logic                      primed_o
);
  localparam int DIS_LSB = 4;

  logic run_q, run_n, keep_q, keep_n, prime_q, prime_n;
  logic [2:0] clr_q, clr_n;
  logic [NC-1:0][1:0] act_q, act_n;
  logic [NC-1:0] init_q, init_n, dis_q, dis_n;
  logic [NC-1:0][CW-1:0] cmp_q, cmp_n;
  logic wr_ctrl, load;

  assign wr_ctrl = wr_en && (wr_addr == AD_CTRL);
  assign load    = wr_ctrl && wr_data[0] && !run_q && (prime_q || wr_data[2]);

  always_comb begin
    run_n   = run_q;
    keep_n  = keep_q;
    prime_n = prime_q;
    clr_n   = clr_q;
    act_n   = act_q;
    init_n  = init_q;
    dis_n   = dis_q;
    cmp_n   = cmp_q;
    if (hit_a_i && !keep_q) run_n = 1'b0;
    if (wr_ctrl) begin
      run_n  = wr_data[0];
      keep_n = wr_data[1];
      if (wr_data[2]) prime_n = 1'b1;
    end
    if (load) prime_n = 1'b0;
    if (wr_en && wr_addr == AD_CLR) clr_n = wr_data[2:0];
    if (wr_en && wr_addr == AD_PIN) begin
      init_n = wr_data[NC-1:0];
      dis_n  = wr_data[DIS_LSB +: NC];
    end
    for (int k = 0; k < NC; k++) begin
      if (wr_en && wr_addr == AD_ACT) act_n[k] = wr_data[4*k +: 2];
      if (wr_en && wr_addr == AD_CMP0 + ADDR_W'(k)) cmp_n[k] = wr_data[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      keep_q  <= 1'b0;
      prime_q <= 1'b1;
      clr_q   <= '0;
      act_q   <= '0;
      init_q  <= '0;
      dis_q   <= '0;
      cmp_q   <= '1;
    end else begin
      run_q   <= run_n;
      keep_q  <= keep_n;
      prime_q <= prime_n;
      clr_q   <= clr_n;
      act_q   <= act_n;
      init_q  <= init_n;
      dis_q   <= dis_n;
      cmp_q   <= cmp_n;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NC; g++) begin : g_fclr
      assign flag_clr_o[g] = wr_en && (wr_addr == AD_FLAG) && !wr_data[g];
    end
  endgenerate

  assign run_o      = run_q;
  assign clr_on_a_o = (clr_q == CLR_ON_A);
  assign act_o      = act_q;
  assign init_o     = init_q;
  assign drv_o      = ~dis_q;
  assign cmp_o      = cmp_q;
  assign load_o     = load;
  assign primed_o   = prime_q;

  // R8
  stop_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a_i && !keep_q && !wr_ctrl) |=> !run_q);
  // R5
  prime_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!prime_q && run_q));
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter
  import cmt_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int NC = NUM_CH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv_i,
  input  logic                  clr_on_a_i,
  input  logic [NC-1:0][CW-1:0] cmp_i,
  output logic [CW-1:0]         cnt_o,
  output logic [NC-1:0]         hit_o
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic [NC-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NC; g++) begin : g_cmp
      assign hit[g] = adv_i && (cnt_q == cmp_i[g]);
    end
  endgenerate

  always_comb begin
    cnt_n = cnt_q;
    if (adv_i) cnt_n = (clr_on_a_i && hit[0]) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;
  assign hit_o = hit;

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(cnt_q));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !(clr_on_a_i && hit[0])) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));
  // R3
  period_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && clr_on_a_i && hit[0]) |=> (cnt_q == '0));
endmodule

// File: rtl/cmt_out_ch.sv
module cmt_out_ch
  import cmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  act_e act_i,
  input  logic load_i,
  input  logic init_i,
  input  logic clr_i,
  output logic lvl_o,
  output logic flag_o
);
  logic lvl_q, lvl_n, flag_q, flag_n;

  always_comb begin
    lvl_n = lvl_q;
    if (load_i) lvl_n = init_i;
    else if (hit_i) begin
      case (act_i)
        ACT_LOW:    lvl_n = 1'b0;
        ACT_HIGH:   lvl_n = 1'b1;
        ACT_TOGGLE: lvl_n = !lvl_q;
        default:    lvl_n = lvl_q;
      endcase
    end
    flag_n = (flag_q && !clr_i) || hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_n;
      flag_q <= flag_n;
    end
  end

  assign lvl_o  = lvl_q;
  assign flag_o = flag_q;

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> flag_q);
  // R4
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && act_i == ACT_TOGGLE && !load_i) |=> (lvl_q != $past(lvl_q)));
  // R9
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_i && !load_i) |=> $stable(lvl_q));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmt_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int NC = NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CW-1:0]     count_o,
  output logic [NC-1:0]     flag_o,
  output logic [NC-1:0]     pin_lvl_o,
  output logic [NC-1:0]     pin_drv_o
);
  logic sync1_q, rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      rst_s_n <= sync1_q;
    end
  end

  logic run, clr_on_a, load, primed, adv;
  logic [NC-1:0][1:0] act;
  logic [NC-1:0] init, drv, fclr, hit, lvl;
  logic [NC-1:0][CW-1:0] cmp;

  assign adv = tick_en && run;

  cmt_regs #(.CW(CW), .NC(NC)) regs_i (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hit_a_i(hit[0]), .run_o(run),
    .clr_on_a_o(clr_on_a), .act_o(act), .init_o(init), .drv_o(drv),
    .cmp_o(cmp), .flag_clr_o(fclr), .load_o(load), .primed_o(primed)
  );

  cmt_counter #(.CW(CW), .NC(NC)) cnt_i (
    .clk(clk), .rst_n(rst_s_n), .adv_i(adv), .clr_on_a_i(clr_on_a),
    .cmp_i(cmp), .cnt_o(count_o), .hit_o(hit)
  );

  genvar g;
  generate
    for (g = 0; g < NC; g++) begin : g_ch
      cmt_out_ch ch_i (
        .clk(clk), .rst_n(rst_s_n), .hit_i(hit[g]), .act_i(act_e'(act[g])),
        .load_i(load), .init_i(init[g]), .clr_i(fclr[g]),
        .lvl_o(lvl[g]), .flag_o(flag_o[g])
      );
      assign pin_lvl_o[g] = primed ? init[g] : lvl[g];
    end
  endgenerate

  assign pin_drv_o = drv;

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!run && !wr_en) |=> ($stable(count_o) && $stable(pin_lvl_o)));
endmodule

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [15:0] count_o;
  logic [2:0]  flag_o, pin_lvl_o, pin_drv_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .count_o(count_o),
    .flag_o(flag_o), .pin_lvl_o(pin_lvl_o), .pin_drv_o(pin_drv_o)
  );

  // ticks[25:22] count[21:6] pins[5:3] flags[2:0]
  localparam logic [25:0] VEC [6] = '{
    {4'd1, 16'd1, 3'b100, 3'b000},
    {4'd2, 16'd3, 3'b110, 3'b010},
    {4'd1, 16'd4, 3'b010, 3'b110},
    {4'd1, 16'd0, 3'b011, 3'b111},
    {4'd5, 16'd0, 3'b010, 3'b111},
    {4'd3, 16'd3, 3'b010, 3'b111}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R1 count", 32'(count_o), 0);
    check("R1 flags", 32'(flag_o), 0);
    check("R1 pins", 32'(pin_lvl_o), 0);
    check("R1 drive", 32'(pin_drv_o), 32'h7);

    wr(3'd1, 16'h0001);   // clear on A
    wr(3'd2, 16'h0923);   // A toggle, B high, C low
    wr(3'd3, 16'h0004);   // init C high
    wr(3'd5, 16'd4);
    wr(3'd6, 16'd2);
    wr(3'd7, 16'd3);
    check("R5 primed level", 32'(pin_lvl_o), 32'h4);
    wr(3'd0, 16'h0003);   // run, keep
    check("R5 start load", 32'(pin_lvl_o), 32'h4);

    // R2 R3 R4 R6 vector walk
    for (int i = 0; i < 6; i++) begin
      ticks(int'(VEC[i][25:22]));
      check("R3 count", 32'(count_o), 32'(VEC[i][21:6]));
      check("R4 pins", 32'(pin_lvl_o), 32'(VEC[i][5:3]));
      check("R6 flags", 32'(flag_o), 32'(VEC[i][2:0]));
    end

    wr(3'd4, 16'h0006);
    check("R6 clear A only", 32'(flag_o), 32'h6);

    wr(3'd0, 16'h0002);   // stop
    ticks(5);
    check("R9 held count", 32'(count_o), 3);
    check("R9 held pins", 32'(pin_lvl_o), 32'h2);
    wr(3'd0, 16'h0003);   // resume
    check("R5 no reload", 32'(pin_lvl_o), 32'h2);
    ticks(2);
    check("R9 resume count", 32'(count_o), 0);
    check("R9 resume pins", 32'(pin_lvl_o), 32'h3);

    wr(3'd4, 16'h0000);
    check("R6 clear all", 32'(flag_o), 0);
    ticks(2);
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'h0000; tick_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    check("R7 match wins", 32'(flag_o), 32'h2);
    check("R7 count", 32'(count_o), 3);

    wr(3'd0, 16'h0001);   // run, stop on A
    ticks(2);
    check("R8 stop count", 32'(count_o), 0);
    ticks(3);
    check("R8 stays stopped", 32'(count_o), 0);
    check("R8 pins", 32'(pin_lvl_o), 32'h2);

    wr(3'd0, 16'h0004);   // re-prime
    check("R5 reprime level", 32'(pin_lvl_o), 32'h4);
    wr(3'd0, 16'h0003);
    check("R5 reload at start", 32'(pin_lvl_o), 32'h4);

    wr(3'd3, 16'h0054);
    check("R10 drive", 32'(pin_drv_o), 32'h2);

    wr(3'd1, 16'h0000);   // free run
    wr(3'd2, 16'h0C00);   // all none, upper bits ignored
    repeat (3) @(negedge clk);
    check("R2 no tick hold", 32'(count_o), 0);
    ticks(6);
    check("R3 past A", 32'(count_o), 6);
    check("R4 none action", 32'(pin_lvl_o), 32'h4);
    ticks(65529);
    check("R3 top", 32'(count_o), 32'hFFFF);
    ticks(1);
    check("R3 wrap", 32'(count_o), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule